// File: doc/BRIEF.md
# Timestamp Counter with Selectable Timebase

This block keeps a free-running 32-bit timestamp that software can read at any moment to tag events. It runs from a 50 MHz system clock and offers three timebases: nanoseconds (advancing by 20 each cycle, so the resolution is 20 ns), microseconds and milliseconds. The count wraps modulo 2^32.

Software reaches the block through a small register bus. It has a strobed read with a registered result and a strobed write. A configuration word selects the timebase in its low byte. A separate control bit holds the count at zero. To restart the timestamp, software writes the configuration with that bit set and then writes it again with the bit cleared. Source codes above the highest legal value park the counter.

Top module: `tstamp_timer`

## Requirements
- R1: After synchronous reset (rst_n low), the configuration reads 0 (source 0, hold bit clear), the count is 0 and bus_rdata is 0.
- R2: Configuration bit 8 is the hold bit. On every clock edge after the edge that stores it as 1, the count is 0. After the edge that stores it as 0, counting resumes from 0.
- R3: With source code 0 in configuration bits 7:0, the count rises by 20 on every clock edge.
- R4: With source code 1, the count rises by 1 once every 50 clock edges.
- R5: With source code 2, the count rises by 1 once every 50,000 clock edges.
- R6: A source code above 2 freezes the count at its present value. Reading the configuration returns the stored code in bits 7:0 unchanged.
- R7: A change of source code restarts the prescaler but keeps the count value. After a change to code 1, the first increment comes 51 edges after the write edge.
- R8: The count sits at byte offset 2 and is read-only. A write there changes nothing. The configuration sits at offset 0 and reads back as {23'b0, hold, source}.
- R9: bus_rdata updates on the edge that samples bus_rd high. It carries the whole register value as it stood just before that edge, and holds between reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 50 MHz system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_addr | input | 4 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |

## Verification
On every cycle, the assertions check these properties:
- the count is zero while held;
- the count is frozen when no tick is raised;
- the 20-unit step in the nanosecond base;
- no back-to-back ticks in the microsecond base;
- no tick on an illegal code or right after a source change;
- configuration readback;
- read data equal to the count one edge earlier.

Only the bench scenarios can show the exact increment per window in each timebase. The same holds for the phase of the first increment after a source change, and for the two-step restart. They also show that a write to the count offset is ignored, because the count keeps its own pace across that write.

// File: rtl/tstamp_pkg.sv
// Package: shared types and codes for the timestamp counter.
// Assumes: source codes are 8 bits wide and codes above SRC_MAX are illegal.
package tstamp_pkg;
    localparam int SRC_W = 8;
    localparam logic [SRC_W-1:0] SRC_NS  = 8'd0;
    localparam logic [SRC_W-1:0] SRC_US  = 8'd1;
    localparam logic [SRC_W-1:0] SRC_MS  = 8'd2;
    localparam logic [SRC_W-1:0] SRC_MAX = SRC_MS;
    localparam int CFG_W = SRC_W + 1;

    typedef struct packed {
        logic             hold;
        logic [SRC_W-1:0] src;
    } tstamp_cfg_t;
endpackage

// File: rtl/tstamp_cfg.sv
// Module: configuration register. Stores the hold bit and source code on a write.
// Assumes: the caller decodes the address; wr_en is one cycle per write.
module tstamp_cfg
    import tstamp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output tstamp_cfg_t      cfg
);
    // Purpose: capture the written configuration, clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     cfg <= '0;
        else if (wr_en) cfg <= tstamp_cfg_t'(wr_data);
    end

    a_r6_cfg_readback: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (cfg == tstamp_cfg_t'($past(wr_data))));
endmodule

// File: rtl/tstamp_presc.sv
// Module: timebase prescaler. Raises tick with a step size for the counter.
// Assumes: one clock period is CLK_NS nanoseconds and divides 1000 evenly.
module tstamp_presc
    import tstamp_pkg::*;
#(
    parameter int CLK_NS = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] src,
    input  logic             hold,
    output logic             tick,
    output logic [7:0]       step
);
    localparam int US_DIV = 1000 / CLK_NS;
    localparam int MS_DIV = 1000000 / CLK_NS;
    localparam int DIV_W  = $clog2(MS_DIV);

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] div_lim;
    logic [SRC_W-1:0] src_prev;
    logic             use_div;
    logic             src_chg;

    // Purpose: choose the divide limit and detect a source change.
    always_comb begin
        use_div = (src == SRC_US) || (src == SRC_MS);
        div_lim = (src == SRC_US) ? DIV_W'(US_DIV - 1) : DIV_W'(MS_DIV - 1);
        src_chg = (src != src_prev);
    end

    // Purpose: run the divider and restart it on hold, change or an idle code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q    <= '0;
            src_prev <= '0;
        end else begin
            src_prev <= src;
            if (hold || src_chg || !use_div || div_q == div_lim) div_q <= '0;
            else                                                 div_q <= div_q + 1'b1;
        end
    end

    // Purpose: form the tick and the amount to add.
    always_comb begin
        tick = !hold && ((src == SRC_NS) || (use_div && !src_chg && div_q == div_lim));
        step = (src == SRC_NS) ? 8'(CLK_NS) : 8'd1;
    end

    a_r6_no_tick_illegal: assert property (@(posedge clk) disable iff (!rst_n)
        (src > SRC_MAX) |-> !tick);
    a_r4_us_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && src == SRC_US) |=> !(tick && src == SRC_US));
    a_r7_restart_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        (src != $past(src) && src != SRC_NS) |-> !tick);
endmodule

// File: rtl/tstamp_count.sv
// Module: the 32-bit timestamp register. It clears while held and adds step on tick.
// Assumes: tick is never raised while hold is set.
module tstamp_count #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             tick,
    input  logic [7:0]       step,
    output logic [CNT_W-1:0] cnt
);
    // Purpose: hold at zero, or advance modulo 2^CNT_W.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) cnt <= '0;
        else if (tick)      cnt <= cnt + CNT_W'(step);
    end

    a_r2_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (cnt == '0));
    a_r6_frozen_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !hold) |=> $stable(cnt));
    a_r3_ns_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !hold && step == 8'd20) |=> (cnt == $past(cnt) + CNT_W'(20)));
endmodule

// File: rtl/tstamp_timer.sv
// Module: top of the timestamp counter. It decodes the bus and registers read data.
// Assumes: single-cycle rd/wr strobes; the count offset is CFG_OFS + 2.
module tstamp_timer
    import tstamp_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 32,
    parameter int CFG_OFS = 0,
    parameter int CLK_NS  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(CFG_OFS);
    localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(CFG_OFS + 2);

    tstamp_cfg_t       cfg;
    logic              tick;
    logic [7:0]        step;
    logic [DATA_W-1:0] cnt;
    logic              cfg_wr;

    assign cfg_wr = bus_wr && (bus_addr == A_CFG);

    tstamp_cfg u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr),
        .wr_data(bus_wdata[CFG_W-1:0]), .cfg(cfg)
    );

    tstamp_presc #(.CLK_NS(CLK_NS)) u_presc (
        .clk(clk), .rst_n(rst_n), .src(cfg.src), .hold(cfg.hold),
        .tick(tick), .step(step)
    );

    tstamp_count #(.CNT_W(DATA_W)) u_count (
        .clk(clk), .rst_n(rst_n), .hold(cfg.hold), .tick(tick),
        .step(step), .cnt(cnt)
    );

    // Purpose: register the addressed value in one cycle on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) bus_rdata <= '0;
        else if (bus_rd) begin
            case (bus_addr)
                A_CFG:   bus_rdata <= DATA_W'(cfg);
                A_CNT:   bus_rdata <= cnt;
                default: bus_rdata <= '0;
            endcase
        end
    end

    a_r9_count_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_CNT) |=> (bus_rdata == $past(cnt)));
    a_r9_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/test_tstamp_timer.sv
// Bench: directed scenarios, one task each, for the timestamp counter.
module test_tstamp_timer;
    localparam int CLK_PERIOD = 20;
    localparam logic [3:0] A_CFG = 4'd0;
    localparam logic [3:0] A_CNT = 4'd2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tstamp_timer i_tstamp_timer (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        chk("R1 rdata after reset", bus_rdata, 32'd0);
        rd(A_CNT, v); chk("R1 count after reset", v, 32'd0);
        rd(A_CFG, v); chk("R1 config after reset", v, 32'd0);
    endtask

    task automatic t_ns;
        logic [31:0] a, b, c, d;
        rd(A_CNT, a); rd(A_CNT, b); rd(A_CNT, c);
        chk("R3 step of 20", b - a, 32'd20);
        chk("R3 step of 20 again", c - b, 32'd20);
        idle(9); rd(A_CNT, d);
        chk("R3 ten edges give 200", d - c, 32'd200);
    endtask

    task automatic t_hold;
        logic [31:0] v;
        wr(A_CFG, 32'h100); idle(1);
        rd(A_CNT, v); chk("R2 held at zero", v, 32'd0);
        idle(5); rd(A_CNT, v); chk("R2 still zero", v, 32'd0);
        wr(A_CFG, 32'h000);
        rd(A_CNT, v); chk("R9 read shows value before edge", v, 32'd0);
        rd(A_CNT, v); chk("R2 resumes from zero", v, 32'd20);
    endtask

    task automatic t_readonly;
        logic [31:0] a, b, c;
        rd(A_CNT, a);
        wr(A_CNT, 32'd0);
        rd(A_CNT, b);
        chk("R8 write to count ignored", b - a, 32'd40);
        rd(A_CFG, c); chk("R8 config untouched", c, 32'd0);
    endtask

    task automatic t_illegal;
        logic [31:0] a, b, c;
        wr(A_CFG, 32'h005); idle(2);
        rd(A_CNT, a); idle(200); rd(A_CNT, b);
        chk("R6 count frozen", b, a);
        rd(A_CFG, c); chk("R6 code read back", c, 32'h005);
        wr(A_CFG, 32'h000);
        rd(A_CNT, b); chk("R7 count kept across change", b, a);
        rd(A_CNT, b); chk("R7 counting from kept value", b, a + 32'd20);
    endtask

    task automatic t_us;
        logic [31:0] a, b;
        wr(A_CFG, 32'h101); wr(A_CFG, 32'h001); idle(3);
        rd(A_CNT, a); idle(499); rd(A_CNT, b);
        chk("R4 500 edges give 10", b - a, 32'd10);
    endtask

    task automatic t_restart;
        logic [31:0] x, y, z;
        wr(A_CFG, 32'h002); wr(A_CFG, 32'h001);
        rd(A_CNT, x); idle(49);
        rd(A_CNT, y); chk("R7 no increment before 51st edge", y, x);
        rd(A_CNT, z); chk("R7 first increment on 51st edge", z, x + 32'd1);
    endtask

    task automatic t_ms;
        logic [31:0] a, b;
        wr(A_CFG, 32'h102); wr(A_CFG, 32'h002);
        rd(A_CNT, a); idle(49999); rd(A_CNT, b);
        chk("R5 50000 edges give 1", b - a, 32'd1);
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ns();
        t_hold();
        t_readonly();
        t_illegal();
        t_us();
        t_restart();
        t_ms();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            finish_run();
        end
    end
endmodule